// File: doc/BRIEF.md
# Command-Controlled Serial Receive Channel

This block is the receive side of an asynchronous serial channel. It oversamples the serial line on a 16x tick and frames characters with one start bit, eight data bits (least significant bit first), no parity and one stop bit. It holds finished characters in a three-entry FIFO that the host reads through a strobe. The host switches the receiver on and off by writing a two-bit command code rather than a plain enable bit.

Each character is stored with a framing-error flag. A ready output shows that data is waiting. A sticky overrun flag records a character that was dropped because all three holding entries were occupied.

Two mode inputs, local loopback and multidrop, keep the receiver running even after a disable command. A stop input models the serial module being halted: while it is high, the buffer cannot be read.

Top module: `uart_rx_chan`

## Requirements
- R1: A command write with code 2'b01 enables the receiver, and code 2'b10 disables it. Codes 2'b00 and 2'b11 leave the enable state as it was.
- R2: With both mode inputs low and the receiver disabled, a complete character on the line is not captured, and `rx_ready_o` stays low.
- R3: A disable command, with both modes low, abandons a character in progress at once. That character is never stored, and the FIFO contents and `overrun_o` are left unchanged.
- R4: While `loopback_i` or `multidrop_i` is high, characters are received even though the enable state is off.
- R5: An enable command issued while the receiver is already enabled does not disturb a character in progress, and that character is received intact.
- R6: An enable command given while the receiver is disabled and `multidrop_i` is low sends the framer back to start-bit search, dropping any partial character. With `multidrop_i` high, the same command does not restart the framer.
- R7: Frames are 8N1, least significant bit first, with 16 ticks of `tick16_i` per bit. A low pulse shorter than half a bit is rejected as a false start.
- R8: A stop bit sampled low at mid-bit stores the character with `rd_ferr_o` set. A high stop bit stores it with `rd_ferr_o` clear.
- R9: The FIFO holds three characters and presents the oldest on `rd_data_o`. `rx_ready_o` is high exactly when at least one character is held, and a read strobe pops one entry.
- R10: A character that completes while three are held is dropped. `overrun_o` then sets and stays set until `ovr_clr_i` is pulsed, and the three held characters are kept.
- R11: While `stop_i` is high, `rd_data_o` and `rd_ferr_o` read as zero and a read strobe pops nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tick16_i | input | 1 | Oversample enable, 16 per bit time |
| rx_i | input | 1 | Serial receive line, idle high |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Receiver command code |
| loopback_i | input | 1 | Local loopback mode select |
| multidrop_i | input | 1 | Multidrop mode select |
| stop_i | input | 1 | Serial module halted |
| rd_i | input | 1 | Buffer read strobe (pop) |
| ovr_clr_i | input | 1 | Clear the overrun flag |
| rd_data_o | output | 8 | Oldest held character |
| rd_ferr_o | output | 1 | Framing error of the oldest character |
| rx_ready_o | output | 1 | At least one character held |
| overrun_o | output | 1 | Sticky overrun flag |

## Verification
The bench aims at the places where the command code and the mode inputs interact. A reserved code that acted as enable or disable would capture characters while off, or lose them while on. A disable that failed to abort would leave a stray character in the FIFO. A restart that ignored multidrop would lose a character that should arrive, or keep one that should be dropped. It also fills the FIFO past three entries to confirm that the oldest three survive and the flag sticks, attempts reads while halted to catch a pop that should not happen, and sends a short low glitch to catch a framer that commits on the falling edge alone.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;
  typedef enum logic [1:0] {
    CMD_NOP   = 2'b00,
    CMD_ON    = 2'b01,
    CMD_OFF   = 2'b10,
    CMD_RSVD  = 2'b11
  } rx_cmd_e;

  typedef enum logic [1:0] {
    FR_IDLE,
    FR_START,
    FR_DATA,
    FR_STOP
  } fr_state_e;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '1;
    else         sh_q <= {sh_q[STAGES-2:0], d_i};
  end

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/rx_framer.sv
module rx_framer
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              restart_i,
  input  logic              rx_i,
  output logic              push_o,
  output logic [DATA_W-1:0] data_o,
  output logic              ferr_o,
  output logic              busy_o
);
  localparam int CNT_W = $clog2(OSR);
  localparam int BIT_W = $clog2(DATA_W);
  localparam logic [CNT_W-1:0] MID  = CNT_W'(OSR/2 - 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(OSR - 1);
  localparam logic [BIT_W-1:0] TOP  = BIT_W'(DATA_W - 1);

  fr_state_e         st_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [BIT_W-1:0]  bit_q;
  logic [DATA_W-1:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= FR_IDLE;
      cnt_q  <= '0;
      bit_q  <= '0;
      sh_q   <= '0;
      push_o <= 1'b0;
      data_o <= '0;
      ferr_o <= 1'b0;
    end else begin
      push_o <= 1'b0;
      if (!run_i || restart_i) begin
        st_q  <= FR_IDLE;
        cnt_q <= '0;
        bit_q <= '0;
      end else if (tick_i) begin
        unique case (st_q)
          FR_IDLE: begin
            cnt_q <= '0;
            if (!rx_i) st_q <= FR_START;
          end
          FR_START: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == MID) begin
              cnt_q <= '0;
              bit_q <= '0;
              st_q  <= rx_i ? FR_IDLE : FR_DATA;  // reject glitch
            end
          end
          FR_DATA: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_q <= '0;
              sh_q  <= {rx_i, sh_q[DATA_W-1:1]};
              bit_q <= bit_q + 1'b1;
              if (bit_q == TOP) st_q <= FR_STOP;
            end
          end
          FR_STOP: begin
            cnt_q <= cnt_q + 1'b1;
            if (cnt_q == LAST) begin
              cnt_q  <= '0;
              push_o <= 1'b1;
              data_o <= sh_q;
              ferr_o <= ~rx_i;
              st_q   <= FR_IDLE;
            end
          end
          default: st_q <= FR_IDLE;
        endcase
      end
    end
  end

  assign busy_o = (st_q != FR_IDLE);
endmodule

// File: rtl/rx_fifo.sv
module rx_fifo #(
  parameter int WIDTH = 9,
  parameter int DEPTH = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] wdata_i,
  input  logic             pop_i,
  input  logic             ovr_clr_i,
  output logic [WIDTH-1:0] head_o,
  output logic             empty_o,
  output logic             overrun_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] PTR_MAX = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0] rd_q, wr_q;
  logic [CNT_W-1:0] cnt_q;
  logic             full, do_pop, do_push, drop;

  assign empty_o = (cnt_q == '0);
  assign full    = (cnt_q == CNT_MAX);
  assign do_pop  = pop_i && !empty_o;
  assign do_push = push_i && (!full || do_pop);
  assign drop    = push_i && !do_push;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_MAX) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push) wr_q <= nxt(wr_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                 mem_q[i] <= '0;
      else if (do_push && wr_q == PTR_W'(i))       mem_q[i] <= wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        overrun_o <= 1'b0;
    else if (drop)      overrun_o <= 1'b1;  // set beats clear
    else if (ovr_clr_i) overrun_o <= 1'b0;
  end

  assign head_o = mem_q[rd_q];
endmodule

// File: rtl/uart_rx_chan.sv
module uart_rx_chan
  import uart_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int DEPTH  = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic              rx_i,
  input  logic              cmd_we_i,
  input  logic [1:0]        cmd_i,
  input  logic              loopback_i,
  input  logic              multidrop_i,
  input  logic              stop_i,
  input  logic              rd_i,
  input  logic              ovr_clr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_ferr_o,
  output logic              rx_ready_o,
  output logic              overrun_o
);
  localparam int ENT_W = DATA_W + 1;

  logic              rx_s;
  logic              rx_en_q, rx_en_d;
  logic              run, restart;
  logic              fr_push, fr_ferr, fr_busy;
  logic [DATA_W-1:0] fr_data;
  logic [ENT_W-1:0]  head;
  logic              empty;

  always_comb begin
    rx_en_d = rx_en_q;
    if (cmd_we_i) begin
      unique case (rx_cmd_e'(cmd_i))
        CMD_ON:  rx_en_d = 1'b1;
        CMD_OFF: rx_en_d = 1'b0;
        default: rx_en_d = rx_en_q;  // nop and reserved
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rx_en_q <= 1'b0;
    else         rx_en_q <= rx_en_d;
  end

  // Decoded from the incoming command so the abort lands on the same edge.
  assign run     = rx_en_d | loopback_i | multidrop_i;
  assign restart = cmd_we_i && (cmd_i == CMD_ON) && !rx_en_q && !multidrop_i;

  rx_sync #(.STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  rx_framer #(.DATA_W(DATA_W), .OSR(OSR)) u_framer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .tick_i   (tick16_i),
    .run_i    (run),
    .restart_i(restart),
    .rx_i     (rx_s),
    .push_o   (fr_push),
    .data_o   (fr_data),
    .ferr_o   (fr_ferr),
    .busy_o   (fr_busy)
  );

  rx_fifo #(.WIDTH(ENT_W), .DEPTH(DEPTH)) u_fifo (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .push_i   (fr_push),
    .wdata_i  ({fr_ferr, fr_data}),
    .pop_i    (rd_i && !stop_i),
    .ovr_clr_i(ovr_clr_i),
    .head_o   (head),
    .empty_o  (empty),
    .overrun_o(overrun_o)
  );

  assign rx_ready_o = !empty;
  assign rd_data_o  = stop_i ? '0 : head[DATA_W-1:0];
  assign rd_ferr_o  = stop_i ? 1'b0 : head[DATA_W];
endmodule

// File: rtl/uart_rx_chan_chk.sv
module uart_rx_chan_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       cmd_we_i,
  input logic [1:0] cmd_i,
  input logic       loopback_i,
  input logic       multidrop_i,
  input logic       stop_i,
  input logic       rd_i,
  input logic       ovr_clr_i,
  input logic       rx_ready_o,
  input logic       overrun_o,
  input logic       rx_en_q,
  input logic       busy
);
  a_r1_nop_keeps_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && (cmd_i == 2'b00 || cmd_i == 2'b11) |=> rx_en_q == $past(rx_en_q));

  a_r1_on_sets_en: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i == 2'b01 |=> rx_en_q);

  a_r3_off_aborts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i && cmd_i == 2'b10 && !loopback_i && !multidrop_i |=> !busy);

  a_r10_sticky_ovr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o && !ovr_clr_i |=> overrun_o);

  a_r10_ovr_when_full: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(overrun_o) |-> rx_ready_o);

  a_r11_stopped_no_pop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i && rd_i && rx_ready_o |=> rx_ready_o);
endmodule

bind uart_rx_chan uart_rx_chan_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cmd_we_i   (cmd_we_i),
  .cmd_i      (cmd_i),
  .loopback_i (loopback_i),
  .multidrop_i(multidrop_i),
  .stop_i     (stop_i),
  .rd_i       (rd_i),
  .ovr_clr_i  (ovr_clr_i),
  .rx_ready_o (rx_ready_o),
  .overrun_o  (overrun_o),
  .rx_en_q    (rx_en_q),
  .busy       (fr_busy)
);

// File: tb/tb_uart_rx_chan.sv
module tb_uart_rx_chan;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       cmd_we = 1'b0;
  logic [1:0] cmd = 2'b00;
  logic       lb = 1'b0, md = 1'b0, stp = 1'b0, rd = 1'b0, oclr = 1'b0;
  logic [7:0] rdata;
  logic       rferr, ready, ovr;
  int         total = 0, bad = 0;

  always #2 clk = ~clk;  // 250 MHz

  uart_rx_chan dut (
    .clk_i(clk), .rst_ni(rst_n), .tick16_i(1'b1), .rx_i(rx),
    .cmd_we_i(cmd_we), .cmd_i(cmd), .loopback_i(lb), .multidrop_i(md),
    .stop_i(stp), .rd_i(rd), .ovr_clr_i(oclr),
    .rd_data_o(rdata), .rd_ferr_o(rferr), .rx_ready_o(ready), .overrun_o(ovr)
  );

  // {data, stop bit level, expected framing error}
  localparam logic [9:0] VEC [6] = '{
    {8'h55, 1'b1, 1'b0}, {8'hA3, 1'b1, 1'b0}, {8'h00, 1'b1, 1'b0},
    {8'hFF, 1'b1, 1'b0}, {8'h80, 1'b0, 1'b1}, {8'h01, 1'b0, 1'b1}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic write_cmd(input logic [1:0] c);
    @(negedge clk); cmd_we = 1'b1; cmd = c;
    @(negedge clk); cmd_we = 1'b0; cmd = 2'b00;
  endtask

  task automatic pop;
    @(negedge clk); rd = 1'b1;
    @(negedge clk); rd = 1'b0;
  endtask

  // cmd_at: bit index (0 = start) during which cmd_mid is written, -1 for none
  task automatic send(input logic [7:0] d, input logic stop_v,
                      input int cmd_at, input logic [1:0] cmd_mid);
    logic [9:0] fr;
    fr = {stop_v, d, 1'b0};
    for (int i = 0; i < 10; i++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        rx = fr[i];
        if (i == cmd_at && c == 8) begin cmd_we = 1'b1; cmd = cmd_mid; end
        else begin cmd_we = 1'b0; cmd = 2'b00; end
      end
    end
    @(negedge clk); rx = 1'b1; cmd_we = 1'b0;
    idle(40);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle(3);
    check(ready == 1'b0, "R9 reset ready", ready, 0);
    check(ovr == 1'b0, "R10 reset overrun", ovr, 0);
    rst_n = 1'b1;
    idle(3);

    // R2: disabled, normal mode
    send(8'h3C, 1'b1, -1, 2'b00);
    check(ready == 1'b0, "R2 disabled capture", ready, 0);
    // R1: reserved and nop keep it off
    write_cmd(2'b11); write_cmd(2'b00);
    send(8'h3C, 1'b1, -1, 2'b00);
    check(ready == 1'b0, "R1 reserved/nop while off", ready, 0);

    write_cmd(2'b01);
    // R7/R8/R9 vector table
    for (int v = 0; v < 6; v++) begin
      send(VEC[v][9:2], VEC[v][1], -1, 2'b00);
      check(ready == 1'b1, "R9 ready after char", ready, 1);
      check(rdata == VEC[v][9:2], "R7 data", rdata, VEC[v][9:2]);
      check(rferr == VEC[v][0], "R8 framing flag", rferr, VEC[v][0]);
      pop();
      check(ready == 1'b0, "R9 empty after pop", ready, 0);
    end

    // R1: reserved and nop keep it on
    write_cmd(2'b11); write_cmd(2'b00);
    send(8'h6E, 1'b1, -1, 2'b00);
    check(rdata == 8'h6E && ready, "R1 reserved/nop while on", rdata, 8'h6E);
    pop();

    // R7: short glitch rejected
    @(negedge clk); rx = 1'b0; idle(4); rx = 1'b1; idle(60);
    check(ready == 1'b0, "R7 glitch rejected", ready, 0);

    // R5: enable while enabled does not restart
    send(8'h5A, 1'b1, 4, 2'b01);
    check(ready && rdata == 8'h5A, "R5 char intact", rdata, 8'h5A);
    pop();

    // R10: overrun
    send(8'h11, 1'b1, -1, 2'b00);
    send(8'h22, 1'b1, -1, 2'b00);
    send(8'h33, 1'b1, -1, 2'b00);
    check(ovr == 1'b0, "R10 no overrun at three", ovr, 0);
    send(8'h44, 1'b1, -1, 2'b00);
    check(ovr == 1'b1, "R10 overrun set", ovr, 1);
    idle(20);
    check(ovr == 1'b1, "R10 overrun sticky", ovr, 1);
    // R11: halted read
    @(negedge clk); stp = 1'b1;
    @(negedge clk);
    check(rdata == 8'h00, "R11 halted data zero", rdata, 0);
    pop();
    stp = 1'b0;
    @(negedge clk);
    check(rdata == 8'h11, "R11 halted read no pop", rdata, 8'h11);
    pop();
    check(rdata == 8'h22, "R10 second kept", rdata, 8'h22);
    pop();
    check(rdata == 8'h33, "R10 third kept", rdata, 8'h33);
    pop();
    check(ready == 1'b0, "R10 fourth dropped", ready, 0);
    @(negedge clk); oclr = 1'b1; @(negedge clk); oclr = 1'b0;
    check(ovr == 1'b0, "R10 overrun cleared", ovr, 0);

    // R3: disable mid-char; earlier entry and overrun preserved
    send(8'h77, 1'b1, -1, 2'b00);
    send(8'h00, 1'b1, 3, 2'b10);
    check(rdata == 8'h77, "R3 fifo unchanged", rdata, 8'h77);
    check(ovr == 1'b0, "R3 overrun unchanged", ovr, 0);
    pop();
    check(ready == 1'b0, "R3 partial discarded", ready, 0);

    // R4: modes keep receiver running while disabled
    lb = 1'b1;
    send(8'hC5, 1'b1, -1, 2'b00);
    check(ready && rdata == 8'hC5, "R4 loopback runs", rdata, 8'hC5);
    pop();
    send(8'h99, 1'b1, 4, 2'b10);
    check(ready && rdata == 8'h99, "R4 disable ignored in loopback", rdata, 8'h99);
    pop();
    lb = 1'b0; md = 1'b1;
    send(8'h2B, 1'b1, -1, 2'b00);
    check(ready && rdata == 8'h2B, "R4 multidrop runs", rdata, 8'h2B);
    pop();

    // R6: enable restarts only with multidrop off
    send(8'hFF, 1'b1, 3, 2'b01);
    check(ready && rdata == 8'hFF, "R6 no restart in multidrop", rdata, 8'hFF);
    pop();
    write_cmd(2'b10);
    md = 1'b0; lb = 1'b1;
    send(8'hFF, 1'b1, 3, 2'b01);
    check(ready == 1'b0, "R6 restart drops partial", ready, 0);
    lb = 1'b0;
    send(8'h4D, 1'b1, -1, 2'b00);
    check(ready && rdata == 8'h4D, "R1 enabled by restart cmd", rdata, 8'h4D);
    pop();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule